// File: doc/BRIEF.md
# Wavetable Voice Sample Address Generator

This block drives one playback voice of a wavetable engine. Software stages five settings through a small write port: the loop base address, the starting sample offset, the loop end offset, a rate increment and a format nibble. A start command copies them into the working set and enables stepping. On every 48 kHz frame tick the voice adds the increment, a 4.12 fixed-point step, to a position made of a 16-bit sample offset and a 12-bit fraction. The offset is counted in sample frames.

The byte address for the sample fetch is the base plus the offset scaled by the frame size: 1, 2 or 4 bytes, set by the stereo and 16-bit format bits. When the integer position moves past the end offset, the offset returns to 0 and the fraction is kept, so the buffer loops. A half-buffer flag shows which half of the loop the voice is in. A one-cycle event pulse marks each change of that flag, which lets the refill logic use the buffer as a ping-pong pair. The effective playback rate is increment × 48000 / 4096 Hz.

Top module: `wt_voice_addr`

## Requirements
- R1: After synchronous reset, running, cur_offset, byte_pos, mem_addr, half_flag and addr_evt are all 0.
- R2: Only bits 29:0 of a base write are kept. mem_addr equals (base + byte_pos) mod 2^30, and every mem_addr bit above 29 is 0.
- R3: On each cycle with tick high while running, the 28-bit position {offset, 12-bit fraction} grows by the 16-bit increment, which is read as 4 integer bits and 12 fraction bits.
- R4: If the integer part after the addition is greater than the end offset, cur_offset becomes 0 and the 12-bit fraction of the sum is kept.
- R5: Format bit 2 (stereo) and bit 3 (16-bit) each double the frame size. byte_pos = cur_offset × frame size, giving 1, 2 or 4 bytes per frame.
- R6: A start whose staged format has bit 0 clear is ignored. running, cur_offset and the working settings do not change.
- R7: half_flag is 1 exactly when cur_offset ≥ (end + 1) / 2, using integer division. It is updated on start and on every step.
- R8: addr_evt is high for one cycle right after a step that changed half_flag. A start never raises it.
- R9: stop clears running. Ticks then leave cur_offset and half_flag unchanged and raise no addr_evt.
- R10: A write with cfg_we high goes to staging only, selected by cfg_sel: 0 base, 1 start offset, 2 end offset, 3 increment, 4 format (bits 3:0). The new value takes effect at the next accepted start.
- R11: When start and tick are high in the same cycle, the load wins. cur_offset equals the staged start offset and no step happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_sel | input | 3 | Staging register select |
| cfg_wdata | input | 32 | Staging write data |
| start | input | 1 | Load working set and run |
| stop | input | 1 | Freeze the voice |
| tick | input | 1 | 48 kHz frame tick, one cycle wide |
| running | output | 1 | Voice is stepping |
| cur_offset | output | 16 | Current sample offset in frames |
| byte_pos | output | 18 | Offset scaled to bytes |
| mem_addr | output | 32 | Byte address of the current sample |
| half_flag | output | 1 | Voice is in the upper half of the loop |
| addr_evt | output | 1 | Pulse on each half-flag change |

## Verification
The hardest case to reach is a step where the wrap and the fraction carry interact. This needs an increment that is not a whole number of frames, so that the discarded integer overshoot and the kept fraction both matter while the half flag flips on the same tick. The bench loads a 1.5-frame increment with a short loop. It walks enough ticks to cross the midpoint and the end several times at different fraction phases, and compares offset, flag and event on every tick against a position model kept in the bench. A second directed case puts the base near the top of the 30-bit space so that the address addition rolls over.

// File: rtl/wt_voice_pkg.sv
package wt_voice_pkg;
    localparam int OFS_W   = 16;
    localparam int FRAC_W  = 12;
    localparam int DELTA_W = 16;
    localparam int BASE_W  = 30;
    localparam int FMT_W   = 4;
    localparam int POS_W   = OFS_W + FRAC_W;
    localparam int BPOS_W  = OFS_W + 2;

    typedef enum logic [2:0] {
        SEL_BASE  = 3'd0,
        SEL_OFS   = 3'd1,
        SEL_END   = 3'd2,
        SEL_DELTA = 3'd3,
        SEL_FMT   = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [BASE_W-1:0]  base;
        logic [OFS_W-1:0]   ofs;
        logic [OFS_W-1:0]   endo;
        logic [DELTA_W-1:0] delta;
        logic [FMT_W-1:0]   fmt;
    } voice_cfg_t;

    // frame size as a power of two: stereo and 16-bit each add one
    function automatic logic [1:0] frame_shift(input logic [FMT_W-1:0] fmt);
        return {1'b0, fmt[2]} + {1'b0, fmt[3]};
    endfunction

    function automatic logic upper_half(input logic [OFS_W-1:0] ofs,
                                        input logic [OFS_W-1:0] endo);
        logic [OFS_W:0] mid;
        mid = ({1'b0, endo} + (OFS_W+1)'(1)) >> 1;
        return {1'b0, ofs} >= mid;
    endfunction
endpackage

// File: rtl/wt_voice_cfg.sv
module wt_voice_cfg
    import wt_voice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output voice_cfg_t        staged
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:BASE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_BASE:  staged.base  <= wdata[BASE_W-1:0];
                SEL_OFS:   staged.ofs   <= wdata[OFS_W-1:0];
                SEL_END:   staged.endo  <= wdata[OFS_W-1:0];
                SEL_DELTA: staged.delta <= wdata[DELTA_W-1:0];
                SEL_FMT:   staged.fmt   <= wdata[FMT_W-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/wt_voice_step.sv
module wt_voice_step
    import wt_voice_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  voice_cfg_t       staged,
    output voice_cfg_t       active,
    output logic [OFS_W-1:0] offset,
    output logic             run,
    output logic             half,
    output logic             evt
);
    logic [FRAC_W-1:0] frac;
    logic [POS_W:0]    sum;
    logic [OFS_W:0]    sum_int;
    logic [OFS_W-1:0]  nxt_ofs;
    logic              nxt_half;
    logic              load_ok;

    assign load_ok = start && staged.fmt[0];

    always_comb begin
        sum      = {1'b0, offset, frac} + (POS_W+1)'(active.delta);
        sum_int  = sum[POS_W:FRAC_W];
        nxt_ofs  = (sum_int > {1'b0, active.endo}) ? '0 : sum_int[OFS_W-1:0];
        nxt_half = upper_half(nxt_ofs, active.endo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            offset <= '0;
            frac   <= '0;
            run    <= 1'b0;
            half   <= 1'b0;
            evt    <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (load_ok) begin
                active <= staged;
                offset <= staged.ofs;
                frac   <= '0;
                run    <= 1'b1;
                half   <= upper_half(staged.ofs, staged.endo);
            end else if (stop) begin
                run <= 1'b0;
            end else if (tick && run) begin
                offset <= nxt_ofs;
                frac   <= sum[FRAC_W-1:0];
                half   <= nxt_half;
                evt    <= nxt_half != half;
            end
        end
    end
endmodule

// File: rtl/wt_voice_addr_gen.sv
module wt_voice_addr_gen
    import wt_voice_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [BASE_W-1:0] base,
    input  logic [FMT_W-1:0]  fmt,
    input  logic [OFS_W-1:0]  offset,
    output logic [BPOS_W-1:0] byte_pos,
    output logic [ADDR_W-1:0] addr
);
    logic [BASE_W-1:0] sum;
    logic              unused_fmt;

    assign unused_fmt = fmt[1] ^ fmt[0];
    assign byte_pos   = {2'b00, offset} << frame_shift(fmt);
    assign sum        = base + BASE_W'(byte_pos);

    generate
        if (ADDR_W > BASE_W) begin : g_wide
            assign addr = {{(ADDR_W-BASE_W){1'b0}}, sum};
        end else begin : g_narrow
            assign addr = sum[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/wt_voice_addr.sv
module wt_voice_addr
    import wt_voice_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              tick,
    output logic              running,
    output logic [OFS_W-1:0]  cur_offset,
    output logic [BPOS_W-1:0] byte_pos,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              half_flag,
    output logic              addr_evt
);
    voice_cfg_t staged;
    voice_cfg_t active;

    wt_voice_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .staged (staged)
    );

    wt_voice_step u_step (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stop   (stop),
        .tick   (tick),
        .staged (staged),
        .active (active),
        .offset (cur_offset),
        .run    (running),
        .half   (half_flag),
        .evt    (addr_evt)
    );

    wt_voice_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base     (active.base),
        .fmt      (active.fmt),
        .offset   (cur_offset),
        .byte_pos (byte_pos),
        .addr     (mem_addr)
    );
endmodule

// File: rtl/wt_voice_chk.sv
module wt_voice_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              tick,
    input logic              running,
    input logic [15:0]       cur_offset,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              half_flag,
    input logic              addr_evt
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!running && !addr_evt && !half_flag));

    generate
        if (ADDR_W > 30) begin : g_hi
            assert_addr_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
                mem_addr[ADDR_W-1:30] == '0);
        end
    endgenerate

    assert_run_needs_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

    assert_evt_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        addr_evt |-> ($past(tick) && !$past(start)));

    assert_evt_flag_moved_R8: assert property (@(posedge clk) disable iff (rst)
        addr_evt |-> (half_flag != $past(half_flag)));

    assert_frozen_when_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(running) && !$past(start)) |-> ($stable(cur_offset) && !addr_evt));
endmodule

bind wt_voice_addr wt_voice_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tick       (tick),
    .running    (running),
    .cur_offset (cur_offset),
    .mem_addr   (mem_addr),
    .half_flag  (half_flag),
    .addr_evt   (addr_evt)
);

// File: tb/test_wt_voice_addr.sv
module test_wt_voice_addr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        tick = 1'b0;
    logic        running;
    logic [15:0] cur_offset;
    logic [17:0] byte_pos;
    logic [31:0] mem_addr;
    logic        half_flag;
    logic        addr_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model of the voice position
    longint m_pos, m_end, m_delta, m_ofs_stage, m_end_stage, m_delta_stage;
    bit     m_half;

    always #4 clk = ~clk;

    wt_voice_addr i_wt_voice_addr (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .stop(stop), .tick(tick),
        .running(running), .cur_offset(cur_offset), .byte_pos(byte_pos),
        .mem_addr(mem_addr), .half_flag(half_flag), .addr_evt(addr_evt)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_half(input longint ofs, input longint e);
        return ofs >= ((e + 1) / 2);
    endfunction

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s == 3'd1) m_ofs_stage = d[15:0];
        if (s == 3'd2) m_end_stage = d[15:0];
        if (s == 3'd3) m_delta_stage = d[15:0];
    endtask

    task automatic setup(input logic [31:0] base, input int ofs, input int e,
                         input int dl, input logic [3:0] fmt);
        wr(3'd0, base); wr(3'd1, ofs); wr(3'd2, e); wr(3'd3, dl); wr(3'd4, {28'd0, fmt});
    endtask

    task automatic go(input bit with_tick);
        @(negedge clk);
        start = 1'b1; tick = with_tick;
        @(negedge clk);
        start = 1'b0; tick = 1'b0;
        m_pos = m_ofs_stage << 12; m_end = m_end_stage; m_delta = m_delta_stage;
        m_half = model_half(m_ofs_stage, m_end_stage);
    endtask

    // one tick, then compare offset, flag and event with the model
    task automatic step_chk(input string tag);
        longint s;
        bit old_half;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        old_half = m_half;
        s = m_pos + m_delta;
        if ((s >> 12) > m_end) m_pos = s & 12'hfff;
        else m_pos = s;
        m_half = model_half(m_pos >> 12, m_end);
        chk({tag, " offset"}, cur_offset, m_pos >> 12);
        chk({tag, " half R7"}, half_flag, m_half);
        chk({tag, " event R8"}, addr_evt, m_half != old_half);
    endtask

    task automatic t_reset;
        chk("R1 running", running, 0);
        chk("R1 offset", cur_offset, 0);
        chk("R1 byte_pos", byte_pos, 0);
        chk("R1 mem_addr", mem_addr, 0);
        chk("R1 half", half_flag, 0);
        chk("R1 evt", addr_evt, 0);
    endtask

    task automatic t_base_mask;
        setup(32'hffff_fff0, 0, 99, 4096, 4'h1);
        go(0);
        chk("R2 masked base", mem_addr, 32'h3fff_fff0);
        chk("R2 running", running, 1);
        for (int i = 0; i < 16; i++) step_chk("R3 unit step");
        chk("R2 rollover", mem_addr, 0);
    endtask

    task automatic t_fraction;
        setup(32'h100, 0, 200, 32'h0800, 4'h1);
        go(0);
        for (int i = 0; i < 7; i++) step_chk("R3 half step");
        chk("R3 offset after 7", cur_offset, 3);
    endtask

    task automatic t_wrap;
        setup(32'h0, 0, 9, 32'h1800, 4'h1);
        go(0);
        for (int i = 0; i < 24; i++) step_chk("R4 wrap");
    endtask

    task automatic t_frames;
        logic [3:0] fm [4] = '{4'h1, 4'h5, 4'h9, 4'hd};
        int sz [4] = '{1, 2, 2, 4};
        for (int k = 0; k < 4; k++) begin
            setup(32'h1000, 5, 50, 4096, fm[k]);
            go(0);
            step_chk("R5 frame");
            chk("R5 byte_pos", byte_pos, 6 * sz[k]);
            chk("R5 mem_addr", mem_addr, 32'h1000 + 6 * sz[k]);
        end
    endtask

    task automatic t_halves;
        int evts = 0;
        setup(32'h0, 0, 7, 4096, 4'h3);
        go(0);
        chk("R7 half at start", half_flag, 0);
        for (int i = 0; i < 16; i++) begin
            step_chk("R8 halves");
            if (addr_evt) evts++;
        end
        chk("R8 event count", evts, 4);
        // start inside the upper half: flag set, no event
        setup(32'h0, 6, 7, 4096, 4'h1);
        go(0);
        chk("R7 half on load", half_flag, 1);
        chk("R8 no event on start", addr_evt, 0);
    endtask

    task automatic t_stop;
        longint held;
        setup(32'h0, 0, 100, 4096, 4'h1);
        go(0);
        for (int i = 0; i < 3; i++) step_chk("R3 pre-stop");
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk("R9 stopped", running, 0);
        held = cur_offset;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            chk("R9 frozen", cur_offset, held);
            chk("R9 no event", addr_evt, 0);
        end
        // format bit 0 clear: start ignored
        wr(3'd4, 32'h4);
        wr(3'd1, 32'h20);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R6 ignored start running", running, 0);
        chk("R6 ignored start offset", cur_offset, held);
    endtask

    task automatic t_staging;
        setup(32'h0, 0, 1000, 4096, 4'h1);
        go(0);
        wr(3'd3, 32'h4000);
        wr(3'd0, 32'h5000);
        m_delta_stage = 32'h4000;
        step_chk("R10 old delta");
        chk("R10 old base", mem_addr, m_pos >> 12);
        wr(3'd7, 32'hffff);
        go(0);
        chk("R10 new base", mem_addr, 32'h5000);
        step_chk("R10 new delta");
        chk("R10 delta four", cur_offset, 4);
    endtask

    task automatic t_start_tick;
        setup(32'h0, 11, 100, 4096, 4'h1);
        go(1);
        chk("R11 load wins", cur_offset, 11);
        step_chk("R11 then steps");
    endtask

    initial begin
        m_ofs_stage = 0; m_end_stage = 0; m_delta_stage = 0;
        m_pos = 0; m_end = 0; m_delta = 0; m_half = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_base_mask();
        t_fraction();
        t_wrap();
        t_frames();
        t_halves();
        t_stop();
        t_staging();
        t_start_tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule